// File: doc/BRIEF.md
# Table-Driven Address Decoder

This block turns a 16-bit processor address into eight device-select lines by reading a writable table. The table has one 8-bit entry for every aligned 8-byte window of the 64 KB space, which gives 8192 entries indexed by address bits 15..3. Each entry is the raw pattern driven onto the select pins. The active level of every pin is already in the stored data, so there is no inversion logic at the outputs. The memory map can be rearranged at run time through a small configuration port. The new value of an entry is used by the next lookup after the write.

The lookup is registered, so the selects follow the address one clock later and are steady before the phase-2 clock rises. The output-enable and write-enable strobes are the read/write line qualified by phase-2. A per-pin polarity mask says which select pins are active-high. A checker uses this mask to convert each entry to active-high and raises a flag whenever more than one device is selected.

After reset, a sweep fills the table with the default map, writing eight entries per clock for 1024 cycles. During the sweep the selects stay idle. Select bit roles in the default map:
- bit 0 is RAM.
- bit 1 is ROM.
- bits 2..7 are peripheral devices 1..6.
- bit 7 is the only active-high pin.

Device 7's window (0xFEE0–0xFEEF) is left unselected in the default map, because all eight pins are already in use.

Top module: `addr_lut_decoder`

## Requirements
- R1: While reset is high and during the 1024-cycle fill sweep that follows it, `dev_sel` holds the idle pattern 0x7F (the bitwise inverse of the default polarity mask 0x80) and `multi_sel` is low.
- R2: `dev_sel` is registered. After the table has been filled, the value on `dev_sel` after clock edge k is the entry selected by `cpu_addr` as sampled at edge k. It does not change between edges.
- R3: Address bits 2..0 have no effect. All eight addresses of an aligned 8-byte window give the same `dev_sel`.
- R4: In the default map, every address from 0x0000 to 0x7FFF drives bit 0 low and all other bits idle (value 0x7E).
- R5: In the default map, addresses 0x8000–0xFBFF and 0xFF00–0xFFFF drive bit 1 low and all other bits idle (value 0x7D).
- R6: In the default map, 0xFC00–0xFE7F and 0xFEE0–0xFEFF select nothing (value 0x7F).
- R7: In the default map, device d (1..6) owns the 16 bytes starting at 0xFE80 + 0x10*(d-1) and is driven on bit d+1. Bits 2..6 are active-low and bit 7 is active-high, so device 6 reads as 0xFF.
- R8: When `cfg_we` is high at a clock edge, entry `cfg_idx` takes `cfg_data`. A lookup of the same entry at that same edge returns the old value, and the lookup at the next edge returns the new one.
- R9: `multi_sel` is high in the same cycle as `dev_sel` exactly when more than one bit of `dev_sel` is active. A bit is active when `dev_sel` equals the polarity mask at that bit position.
- R10: When `cfg_pol_we` is high at a clock edge, the polarity mask takes `cfg_data`. From that edge on, both the activity judgement of R9 and the idle pattern use the new mask.
- R11: `rd_n` is low only while `phi2` is high and `cpu_rw` is 1. `wr_n` is low only while `phi2` is high and `cpu_rw` is 0. Both strobes are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the fill sweep |
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| phi2 | input | 1 | Phase-2 clock used to qualify the strobes |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 13 | Index of the table entry to write |
| cfg_data | input | 8 | Entry pattern, or the new mask when `cfg_pol_we` is high |
| cfg_pol_we | input | 1 | Polarity mask write strobe |
| dev_sel | output | 8 | Registered device-select pattern |
| rd_n | output | 1 | Active-low output enable |
| wr_n | output | 1 | Active-low write enable |
| multi_sel | output | 1 | More than one device is active |

## Verification
A configuration write and a lookup of the very same entry can land on one clock edge. The bench provokes this by presenting the address of the entry being rewritten in the same cycle that `cfg_we` is high. It then requires the old pattern on the next cycle and the new pattern one cycle later. A polarity mask write can also meet a lookup in the same cycle. This is judged by sweeping all 256 entry patterns under two different masks and comparing `multi_sel` with a population count made in the bench.

// File: rtl/addr_lut_pkg.sv
package addr_lut_pkg;

    localparam int ADDR_W = 16;
    localparam int GRAN_W = 3;
    localparam int IDX_W  = ADDR_W - GRAN_W;
    localparam int NSEL   = 8;
    localparam int LANE_W = 3;
    localparam int LANES  = 1 << LANE_W;
    localparam int ROW_W  = IDX_W - LANE_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int WORD_W = LANES * NSEL;

    typedef logic [NSEL-1:0]   sel_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] word_t;

    // Select pin roles in the default map
    localparam int SEL_RAM  = 0;
    localparam int SEL_ROM  = 1;
    localparam int SEL_DEV1 = 2;

    // 1 = pin is active-high
    localparam sel_t DEFAULT_POL = sel_t'(8'h80);

    typedef struct packed {
        logic we;
        idx_t idx;
        sel_t data;
    } cfg_wr_t;

    // Active-high view to raw pin pattern under a polarity mask
    function automatic sel_t to_raw(input sel_t act, input sel_t pol);
        return act ^ ~pol;
    endfunction

    function automatic sel_t default_entry(input idx_t idx);
        logic [ADDR_W-1:0] base;
        sel_t act;
        base = {idx, {GRAN_W{1'b0}}};
        act  = '0;
        if (base < 16'h8000) begin
            act[SEL_RAM] = 1'b1;
        end else if (base >= 16'hFC00 && base < 16'hFF00) begin
            if (base >= 16'hFE80 && base < 16'hFEE0)
                act[SEL_DEV1 + int'(base[6:4])] = 1'b1;
        end else begin
            act[SEL_ROM] = 1'b1;
        end
        return to_raw(act, DEFAULT_POL);
    endfunction

    function automatic word_t default_row(input logic [ROW_W-1:0] row);
        word_t w;
        w = '0;
        for (int l = 0; l < LANES; l++)
            w[l*NSEL +: NSEL] = default_entry({row, LANE_W'(l)});
        return w;
    endfunction

endpackage

// File: rtl/addr_lut_store.sv
module addr_lut_store
    import addr_lut_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cfg_wr_t cfg,
    input  idx_t    look_idx,
    input  sel_t    idle,
    output sel_t    sel_q,
    output logic    init_busy
);

    word_t             mem [ROWS];
    logic [ROW_W-1:0]  init_row;

    logic [ROW_W-1:0]  look_row;
    logic [LANE_W-1:0] look_lane;
    logic [ROW_W-1:0]  wr_row;
    logic [LANE_W-1:0] wr_lane;

    assign look_row  = look_idx[IDX_W-1:LANE_W];
    assign look_lane = look_idx[LANE_W-1:0];
    assign wr_row    = cfg.idx[IDX_W-1:LANE_W];
    assign wr_lane   = cfg.idx[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            init_busy <= 1'b1;
            init_row  <= '0;
            sel_q     <= ~DEFAULT_POL;
        end else if (init_busy) begin
            mem[init_row] <= default_row(init_row);
            init_row      <= init_row + 1'b1;
            if (init_row == ROW_W'(ROWS - 1))
                init_busy <= 1'b0;
            sel_q <= idle;
        end else begin
            if (cfg.we)
                mem[wr_row][int'(wr_lane)*NSEL +: NSEL] <= cfg.data;
            sel_q <= mem[look_row][int'(look_lane)*NSEL +: NSEL];
        end
    end

endmodule

// File: rtl/addr_sel_check.sv
module addr_sel_check
    import addr_lut_pkg::*;
(
    input  sel_t raw,
    input  sel_t pol,
    output logic multi
);

    sel_t act;

    for (genvar g = 0; g < NSEL; g++) begin : g_norm
        assign act[g] = pol[g] ? raw[g] : ~raw[g];
    end

    always_comb begin
        multi = ($countones(act) > 1);
    end

endmodule

// File: rtl/addr_strobe_gate.sv
module addr_strobe_gate (
    input  logic phi2,
    input  logic rw,
    output logic rd_n,
    output logic wr_n
);

    always_comb begin
        rd_n = ~(phi2 & rw);
        wr_n = ~(phi2 & ~rw);
    end

endmodule

// File: rtl/addr_lut_decoder.sv
module addr_lut_decoder
    import addr_lut_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rw,
    input  logic              phi2,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [NSEL-1:0]   cfg_data,
    input  logic              cfg_pol_we,
    output logic [NSEL-1:0]   dev_sel,
    output logic              rd_n,
    output logic              wr_n,
    output logic              multi_sel
);

    sel_t    pol_q;
    sel_t    sel_q;
    logic    init_busy;
    cfg_wr_t cfg;

    always_ff @(posedge clk) begin
        if (rst)
            pol_q <= DEFAULT_POL;
        else if (cfg_pol_we)
            pol_q <= cfg_data;
    end

    always_comb begin
        cfg.we   = cfg_we;
        cfg.idx  = cfg_idx;
        cfg.data = cfg_data;
    end

    addr_lut_store u_store (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .look_idx  (cpu_addr[ADDR_W-1:GRAN_W]),
        .idle      (~pol_q),
        .sel_q     (sel_q),
        .init_busy (init_busy)
    );

    addr_sel_check u_check (
        .raw   (sel_q),
        .pol   (pol_q),
        .multi (multi_sel)
    );

    addr_strobe_gate u_strobe (
        .phi2 (phi2),
        .rw   (cpu_rw),
        .rd_n (rd_n),
        .wr_n (wr_n)
    );

    assign dev_sel = sel_q;

endmodule

// File: rtl/addr_lut_decoder_chk.sv
module addr_lut_decoder_chk
    import addr_lut_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rw,
    input logic              phi2,
    input logic              cfg_we,
    input logic              cfg_pol_we,
    input logic [NSEL-1:0]   dev_sel,
    input logic              rd_n,
    input logic              wr_n,
    input logic              multi_sel,
    input logic              init_busy,
    input logic [NSEL-1:0]   pol_q
);

    // R1: selects stay idle throughout the fill sweep
    a_r1_idle_during_fill: assert property (@(posedge clk) disable iff (rst)
        init_busy |=> (dev_sel == ~$past(pol_q)));

    // R2 / R8: with no table or mask change and the same window, selects hold
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        (!init_busy && !$past(init_busy) && !cfg_we && !$past(cfg_we) &&
         !cfg_pol_we && $stable(cpu_addr[ADDR_W-1:GRAN_W]))
        |=> $stable(dev_sel));

    // R9: the multiple-select flag never appears on the idle pattern
    a_r9_flag_not_idle: assert property (@(posedge clk) disable iff (rst)
        multi_sel |-> (dev_sel != ~pol_q));

    // R11: no strobe while phase-2 is low
    a_r11_quiet_phi2_low: assert property (@(posedge clk) disable iff (rst)
        !phi2 |-> (rd_n && wr_n));

    // R11: the two strobes are never active together
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~rd_n, ~wr_n}) <= 1);

    // R11: the strobe follows the read/write line while phase-2 is high
    a_r11_dir_match: assert property (@(posedge clk) disable iff (rst)
        phi2 |-> (rd_n == !cpu_rw));

endmodule

bind addr_lut_decoder addr_lut_decoder_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_addr   (cpu_addr),
    .cpu_rw     (cpu_rw),
    .phi2       (phi2),
    .cfg_we     (cfg_we),
    .cfg_pol_we (cfg_pol_we),
    .dev_sel    (dev_sel),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .multi_sel  (multi_sel),
    .init_busy  (init_busy),
    .pol_q      (pol_q)
);

// File: tb/sim_addr_lut_decoder.sv
`timescale 1ns/1ps
module sim_addr_lut_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic        phi2 = 1'b0;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_idx = '0;
    logic [7:0]  cfg_data = '0;
    logic        cfg_pol_we = 1'b0;
    logic [7:0]  dev_sel;
    logic        rd_n;
    logic        wr_n;
    logic        multi_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    addr_lut_decoder u0 (
        .clk        (clk),
        .rst        (rst),
        .cpu_addr   (cpu_addr),
        .cpu_rw     (cpu_rw),
        .phi2       (phi2),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_data   (cfg_data),
        .cfg_pol_we (cfg_pol_we),
        .dev_sel    (dev_sel),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .multi_sel  (multi_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Default map, computed from the requirements (active-low except bit 7)
    function automatic logic [7:0] exp_default(input int a);
        logic [7:0] act;
        act = 8'h00;
        if (a < 32768)                      act = 8'h01;
        else if (a >= 'hFE80 && a < 'hFEE0) act = 8'(1 << (2 + (a - 'hFE80) / 16));
        else if (a >= 'hFC00 && a < 'hFF00) act = 8'h00;
        else                                act = 8'h02;
        return act ^ 8'h7F;
    endfunction

    function automatic string region_tag(input int a);
        if (a < 32768)                      return "R4";
        if (a >= 'hFE80 && a < 'hFEE0)      return "R7";
        if (a >= 'hFC00 && a < 'hFF00)      return "R6";
        return "R5";
    endfunction

    function automatic logic exp_multi(input logic [7:0] raw, input logic [7:0] pol);
        return $countones(~(raw ^ pol)) > 1;
    endfunction

    task automatic write_entry(input logic [12:0] idx, input logic [7:0] v);
        cfg_idx  = idx;
        cfg_data = v;
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic pattern_sweep(input logic [7:0] pol, input string req);
        cpu_addr = 16'h2000;
        for (int v = 0; v < 256; v++) begin
            write_entry(13'h0400, 8'(v));
            @(negedge clk);
            chk("R8", 32'(dev_sel), 32'(v));
            chk(req, 32'(multi_sel), 32'(exp_multi(8'(v), pol)));
        end
    endtask

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Reset state (R1)
        repeat (4) @(negedge clk);
        chk("R1", 32'(dev_sel), 32'h7F);
        chk("R1", 32'(multi_sel), 32'h0);
        chk("R11", 32'({rd_n, wr_n}), 32'h3);
        rst = 1'b0;

        // Idle during the fill sweep (R1)
        cpu_addr = 16'h0000;
        repeat (10) @(negedge clk);
        chk("R1", 32'(dev_sel), 32'h7F);
        repeat (1030) @(negedge clk);

        // Full default-map sweep, varying the low bits (R3..R7)
        for (int i = 0; i < 8192; i++) begin
            cpu_addr = 16'((i << 3) | (i % 8));
            @(negedge clk);
            chk(region_tag(i << 3), 32'(dev_sel), 32'(exp_default(i << 3)));
            chk("R9", 32'(multi_sel), 32'h0);
        end

        // Every address in one window matches (R3)
        for (int lo = 0; lo < 8; lo++) begin
            cpu_addr = 16'hFE88 + 16'(lo);
            @(negedge clk);
            chk("R3", 32'(dev_sel), 32'h7B);
        end

        // Registered latency (R2): the output holds until the next edge
        cpu_addr = 16'h1234;
        @(negedge clk);
        chk("R2", 32'(dev_sel), 32'h7E);
        cpu_addr = 16'hC000;
        #1;
        chk("R2", 32'(dev_sel), 32'h7E);
        @(negedge clk);
        chk("R2", 32'(dev_sel), 32'h7D);
        cpu_addr = 16'hFED8;
        @(negedge clk);
        chk("R7", 32'(dev_sel), 32'hFF);

        // Write and lookup of the same entry on the same edge (R8)
        cpu_addr = 16'h1000;
        write_entry(13'h0200, 8'h6F);
        chk("R8", 32'(dev_sel), 32'h7E);
        @(negedge clk);
        chk("R8", 32'(dev_sel), 32'h6F);
        cpu_addr = 16'h1008;
        @(negedge clk);
        chk("R8", 32'(dev_sel), 32'h7E);

        // All entry patterns under the default mask (R9)
        pattern_sweep(8'h80, "R9");

        // New mask: all pins active-high (R10)
        cfg_data   = 8'hFF;
        cfg_pol_we = 1'b1;
        @(negedge clk);
        cfg_pol_we = 1'b0;
        pattern_sweep(8'hFF, "R10");

        // Idle pattern under the new mask after reset-free re-entry: RAM entry raw 0x7E now shows six+ active
        cpu_addr = 16'h0000;
        @(negedge clk);
        @(negedge clk);
        chk("R10", 32'(multi_sel), 32'h1);

        // Strobes, all combinations (R11)
        for (int p = 0; p < 2; p++) begin
            for (int r = 0; r < 2; r++) begin
                phi2   = p[0];
                cpu_rw = r[0];
                #1;
                chk("R11", 32'(rd_n), 32'(!(p == 1 && r == 1)));
                chk("R11", 32'(wr_n), 32'(!(p == 1 && r == 0)));
            end
        end
        phi2 = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule